// File: doc/BRIEF.md
# Hashed Page Table Walker

When a translation lookup misses on either the instruction side or the data side, this block fetches one candidate translation from a page table held in memory. It does not write it anywhere: it hands the entry to the translation cache for installation. A configuration input supplies an enable, a table base address, a table size exponent and a format bit. With the format bit clear, the table is a linear table with 8-byte entries, indexed separately for each region. With the format bit set, it is one shared hash table with 32-byte entries.

The walker computes exactly one entry address and issues one read, sized to the format. It then ends the walk with exactly one of three results: an install pulse carrying the entry, a not-found pulse (which the core turns into a page fault), or a fault pulse when the walker's own table read could not be translated. It never follows a collision chain and has no write path, so accessed and dirty bits are never touched.

Only one walk is in flight at a time. The controller steps through these states:

- S_IDLE: waits for a request. It moves to S_ISSUE on an accepted request when enabled, or to S_NOTFOUND when disabled.
- S_ISSUE: holds the read request. It moves to S_WAIT when the read is accepted.
- S_WAIT: waits for the response. It moves to S_FAULT on a translation miss, to S_INSTALL when the entry is usable, and to S_NOTFOUND otherwise.
- S_INSTALL, S_NOTFOUND and S_FAULT: each asserts its result pulse for one cycle and then returns to S_IDLE.

Top module: `hashed_walker`

## Requirements
- R1: `miss_ready` is high exactly when no walk is in progress. It is low from the cycle after a request is accepted until the cycle after that walk's result pulse.
- R2: A request accepted with `cfg_en` low produces `nf_pulse` in the next cycle and issues no read.
- R3: In short format (`cfg_long`=0), `rd_addr` = base + (((vpn×8) mod 2^size) OR (rid << size)), taken modulo 2^ADDR_W.
- R4: In long format (`cfg_long`=1), `rd_addr` = base + (((rid XOR vpn)×32) mod 2^size). With size 5, the table has a single entry at the base address.
- R5: `rd_long` is 1 for a 32-byte long-format read and 0 for an 8-byte short-format read.
- R6: `rd_req` rises in the cycle after acceptance. It stays high with a stable `rd_addr` until a cycle with `rd_ready` high, and is low afterwards.
- R7: A response with `rd_xmiss` high produces `fault_pulse` in the cycle after `rd_rvalid`, and no install.
- R8: A response whose present bit (`rd_data[0]`) is 0 produces `nf_pulse` in the cycle after `rd_rvalid`.
- R9: In long format, the tag field `rd_data[91:64]` must equal {rid, vpn}, or the result is `nf_pulse`. In short format, bits above 63 are ignored, so a mismatching tag there still installs.
- R10: A usable entry produces `inst_valid` in the cycle after `rd_rvalid`. The pulse carries the request's rid, vpn, page size, side and format. `inst_data` carries the full 256 bits in long format, and bits [63:0] with the upper bits zero in short format.
- R11: Each walk yields exactly one of `inst_valid`, `nf_pulse` or `fault_pulse`. Each of these lasts one cycle.
- R12: The configuration and request inputs are sampled at acceptance. Changing them during a walk does not alter `rd_addr`, `rd_long` or the result.
- R13: Reset in the middle of a walk returns the block to idle, with `miss_ready` high and `rd_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Walker enable |
| cfg_long | input | 1 | Format select: 1 selects the long hash table, 0 the short linear table |
| cfg_base | input | ADDR_W | Table base address |
| cfg_size | input | SIZE_W | Table size exponent (log2 of the size in bytes) |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Walker can accept a request |
| miss_rid | input | RID_W | Region identifier of the miss |
| miss_vpn | input | VPN_W | Virtual page number of the miss |
| miss_ps | input | PS_W | Page size of the miss |
| miss_side | input | 1 | 1 for an instruction-side miss, 0 for a data-side miss |
| rd_req | output | 1 | Table read request |
| rd_addr | output | ADDR_W | Entry address |
| rd_long | output | 1 | Read size: 1 for 32 bytes, 0 for 8 bytes |
| rd_ready | input | 1 | Read request accepted |
| rd_rvalid | input | 1 | Read response valid |
| rd_xmiss | input | 1 | The table access missed in translation |
| rd_data | input | 256 | Read response data |
| inst_valid | output | 1 | Install pulse |
| inst_long | output | 1 | Format of the installed entry |
| inst_side | output | 1 | Side of the installed entry |
| inst_rid | output | RID_W | Region identifier to install |
| inst_vpn | output | VPN_W | Virtual page number to install |
| inst_ps | output | PS_W | Page size to install |
| inst_data | output | 256 | Entry contents |
| nf_pulse | output | 1 | Not-found result pulse |
| fault_pulse | output | 1 | Table-translation fault pulse |

## Verification
The hardest situation to reach from the ports is a change of configuration while a walk is already in flight, together with a read that is held off for several cycles. The entry address must stay frozen through both. To reach it, the stimulus scrambles the base, size and format in the cycle right after acceptance, then holds `rd_ready` low for a number of cycles set in each vector, checking the address on every cycle. Response contents are built to isolate each reason for failure on its own: a clear present bit, a tag mismatch that matters only in long format, and a translation miss on a present entry.

// File: rtl/hpw_pkg.sv
package hpw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_INSTALL,
        S_NOTFOUND,
        S_FAULT
    } walk_state_e;

    // Entry geometry shared by the walker and its consumers
    localparam int ENTRY_W      = 256;  // long entry, 32 bytes
    localparam int SHORT_W      = 64;   // short entry, 8 bytes
    localparam int PRESENT_BIT  = 0;
    localparam int TAG_LSB      = 64;
    localparam int SHORT_SHIFT  = 3;    // log2 of 8 bytes
    localparam int LONG_SHIFT   = 5;    // log2 of 32 bytes

endpackage

// File: rtl/hpw_index.sv
module hpw_index
    import hpw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int RID_W  = 8,
    parameter int VPN_W  = 20,
    parameter int SIZE_W = 5
) (
    input  logic              fmt_long,
    input  logic [ADDR_W-1:0] base,
    input  logic [SIZE_W-1:0] size,
    input  logic [RID_W-1:0]  rid,
    input  logic [VPN_W-1:0]  vpn,
    output logic [ADDR_W-1:0] entry_addr
);

    logic [ADDR_W-1:0] span_mask;
    logic [ADDR_W-1:0] lin_off;
    logic [ADDR_W-1:0] hash_key;
    logic [ADDR_W-1:0] hash_off;

    always_comb begin
        // bytes covered by the table: 2^size, saturating at the address width
        if (int'(size) >= ADDR_W)
            span_mask = '1;
        else
            span_mask = (ADDR_W'(1) << size) - ADDR_W'(1);

        // linear: page slot within the region, region placed above the span
        lin_off  = ((ADDR_W'(vpn) << SHORT_SHIFT) & span_mask)
                 | (ADDR_W'(rid) << size);

        // hashed: folded key, wrapped to the table
        hash_key = ADDR_W'(rid) ^ ADDR_W'(vpn);
        hash_off = (hash_key << LONG_SHIFT) & span_mask;

        entry_addr = base + (fmt_long ? hash_off : lin_off);
    end

endmodule

// File: rtl/hpw_entry_check.sv
module hpw_entry_check #(
    parameter int RID_W = 8,
    parameter int VPN_W = 20
) (
    input  logic                   fmt_long,
    input  logic                   present_bit,
    input  logic [RID_W+VPN_W-1:0] tag_field,
    input  logic [RID_W-1:0]       rid,
    input  logic [VPN_W-1:0]       vpn,
    output logic                   usable
);

    logic tag_hit;

    always_comb begin
        tag_hit = (tag_field == {rid, vpn});
        // the short form carries no tag, only the present bit matters
        usable  = present_bit && (!fmt_long || tag_hit);
    end

endmodule

// File: rtl/hpw_ctrl.sv
module hpw_ctrl
    import hpw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        miss_valid,
    input  logic        cfg_en,
    input  logic        rd_ready,
    input  logic        rd_rvalid,
    input  logic        rd_xmiss,
    input  logic        entry_ok,
    output logic        miss_ready,
    output logic        take_req,
    output logic        take_data,
    output logic        rd_req,
    output logic        inst_pulse,
    output logic        nf_pulse,
    output logic        fault_pulse
);

    walk_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (miss_valid)
                    state_d = cfg_en ? S_ISSUE : S_NOTFOUND;
            end
            S_ISSUE: begin
                if (rd_ready)
                    state_d = S_WAIT;
            end
            S_WAIT: begin
                if (rd_rvalid) begin
                    if (rd_xmiss)
                        state_d = S_FAULT;
                    else if (entry_ok)
                        state_d = S_INSTALL;
                    else
                        state_d = S_NOTFOUND;
                end
            end
            S_INSTALL,
            S_NOTFOUND,
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        miss_ready  = 1'b0;
        take_req    = 1'b0;
        take_data   = 1'b0;
        rd_req      = 1'b0;
        inst_pulse  = 1'b0;
        nf_pulse    = 1'b0;
        fault_pulse = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                miss_ready = 1'b1;
                take_req   = miss_valid;
            end
            S_ISSUE:    rd_req      = 1'b1;
            S_WAIT:     take_data   = rd_rvalid;
            S_INSTALL:  inst_pulse  = 1'b1;
            S_NOTFOUND: nf_pulse    = 1'b1;
            S_FAULT:    fault_pulse = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/hashed_walker.sv
module hashed_walker
    import hpw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int RID_W  = 8,
    parameter int VPN_W  = 20,
    parameter int SIZE_W = 5,
    parameter int PS_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_long,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [SIZE_W-1:0]  cfg_size,
    input  logic               miss_valid,
    output logic               miss_ready,
    input  logic [RID_W-1:0]   miss_rid,
    input  logic [VPN_W-1:0]   miss_vpn,
    input  logic [PS_W-1:0]    miss_ps,
    input  logic               miss_side,
    output logic               rd_req,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic               rd_long,
    input  logic               rd_ready,
    input  logic               rd_rvalid,
    input  logic               rd_xmiss,
    input  logic [ENTRY_W-1:0] rd_data,
    output logic               inst_valid,
    output logic               inst_long,
    output logic               inst_side,
    output logic [RID_W-1:0]   inst_rid,
    output logic [VPN_W-1:0]   inst_vpn,
    output logic [PS_W-1:0]    inst_ps,
    output logic [ENTRY_W-1:0] inst_data,
    output logic               nf_pulse,
    output logic               fault_pulse
);

    localparam int TAG_W = RID_W + VPN_W;
    localparam logic [ENTRY_W-1:0] SHORT_MASK = ENTRY_W'({SHORT_W{1'b1}});

    logic               take_req, take_data, entry_ok;
    logic [ADDR_W-1:0]  idx_addr;

    logic               fmt_q, side_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [RID_W-1:0]   rid_q;
    logic [VPN_W-1:0]   vpn_q;
    logic [PS_W-1:0]    ps_q;
    logic [ENTRY_W-1:0] data_q;

    hpw_index #(
        .ADDR_W (ADDR_W),
        .RID_W  (RID_W),
        .VPN_W  (VPN_W),
        .SIZE_W (SIZE_W)
    ) u_index (
        .fmt_long   (cfg_long),
        .base       (cfg_base),
        .size       (cfg_size),
        .rid        (miss_rid),
        .vpn        (miss_vpn),
        .entry_addr (idx_addr)
    );

    hpw_entry_check #(
        .RID_W (RID_W),
        .VPN_W (VPN_W)
    ) u_check (
        .fmt_long    (fmt_q),
        .present_bit (rd_data[PRESENT_BIT]),
        .tag_field   (rd_data[TAG_LSB +: TAG_W]),
        .rid         (rid_q),
        .vpn         (vpn_q),
        .usable      (entry_ok)
    );

    hpw_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_valid  (miss_valid),
        .cfg_en      (cfg_en),
        .rd_ready    (rd_ready),
        .rd_rvalid   (rd_rvalid),
        .rd_xmiss    (rd_xmiss),
        .entry_ok    (entry_ok),
        .miss_ready  (miss_ready),
        .take_req    (take_req),
        .take_data   (take_data),
        .rd_req      (rd_req),
        .inst_pulse  (inst_valid),
        .nf_pulse    (nf_pulse),
        .fault_pulse (fault_pulse)
    );

    // request and configuration are frozen at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q  <= 1'b0;
            side_q <= 1'b0;
            addr_q <= '0;
            rid_q  <= '0;
            vpn_q  <= '0;
            ps_q   <= '0;
        end else if (take_req) begin
            fmt_q  <= cfg_long;
            side_q <= miss_side;
            addr_q <= idx_addr;
            rid_q  <= miss_rid;
            vpn_q  <= miss_vpn;
            ps_q   <= miss_ps;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else if (take_data)
            data_q <= rd_data;
    end

    always_comb begin
        rd_addr   = addr_q;
        rd_long   = fmt_q;
        inst_long = fmt_q;
        inst_side = side_q;
        inst_rid  = rid_q;
        inst_vpn  = vpn_q;
        inst_ps   = ps_q;
        inst_data = fmt_q ? data_q : (data_q & SHORT_MASK);
    end

endmodule

// File: rtl/hpw_checker.sv
module hpw_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic              cfg_en,
    input logic              rd_req,
    input logic              rd_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_rvalid,
    input logic              rd_xmiss,
    input logic              rd_present,
    input logic              inst_valid,
    input logic              nf_pulse,
    input logic              fault_pulse
);

    logic busy;
    logic any_result;

    assign any_result = inst_valid | nf_pulse | fault_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (miss_valid && miss_ready)
            busy <= 1'b1;
        else if (any_result)
            busy <= 1'b0;
    end

    // R1
    busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !miss_ready);

    // R2
    off_notfound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready && !cfg_en) |=> (nf_pulse && !rd_req));

    // R6
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));

    // R6
    drop_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ready) |=> !rd_req);

    // R7
    xmiss_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_req && !any_result && rd_rvalid && rd_xmiss)
        |=> (fault_pulse && !inst_valid));

    // R8
    absent_nf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_req && !any_result && rd_rvalid && !rd_xmiss && !rd_present)
        |=> nf_pulse);

    // R11
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inst_valid, nf_pulse, fault_pulse}));

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_result |=> !any_result);

endmodule

bind hashed_walker hpw_checker #(.ADDR_W(ADDR_W)) u_hpw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_valid  (miss_valid),
    .miss_ready  (miss_ready),
    .cfg_en      (cfg_en),
    .rd_req      (rd_req),
    .rd_ready    (rd_ready),
    .rd_addr     (rd_addr),
    .rd_rvalid   (rd_rvalid),
    .rd_xmiss    (rd_xmiss),
    .rd_present  (rd_data[0]),
    .inst_valid  (inst_valid),
    .nf_pulse    (nf_pulse),
    .fault_pulse (fault_pulse)
);

// File: tb/hashed_walker_bench.sv
module hashed_walker_bench;

    typedef struct packed {
        logic        fmt_long;
        logic        en;
        logic [4:0]  size;
        logic [31:0] base;
        logic [7:0]  rid;
        logic [19:0] vpn;
        logic        present;
        logic        tag_ok;
        logic        xmiss;
        logic [1:0]  stall;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 5'd16, 32'h1000_0000, 8'h12, 20'h0ABCD, 1'b1, 1'b1, 1'b0, 2'd0},
        '{1'b1, 1'b1, 5'd20, 32'h2000_0000, 8'h34, 20'hF0F0F, 1'b1, 1'b1, 1'b0, 2'd2},
        '{1'b1, 1'b1, 5'd12, 32'h0004_0000, 8'hFF, 20'h00100, 1'b1, 1'b0, 1'b0, 2'd1},
        '{1'b0, 1'b1, 5'd10, 32'h0000_0000, 8'h01, 20'hFFFFF, 1'b1, 1'b0, 1'b0, 2'd0},
        '{1'b0, 1'b1, 5'd14, 32'h8000_0000, 8'hA5, 20'h12345, 1'b0, 1'b1, 1'b0, 2'd0},
        '{1'b1, 1'b1, 5'd16, 32'h1234_0000, 8'h0F, 20'h55555, 1'b1, 1'b1, 1'b1, 2'd3},
        '{1'b0, 1'b1, 5'd12, 32'h0ABC_0000, 8'h77, 20'h00ABC, 1'b1, 1'b1, 1'b1, 2'd1},
        '{1'b0, 1'b0, 5'd16, 32'h4000_0000, 8'h21, 20'h11111, 1'b1, 1'b1, 1'b0, 2'd0},
        '{1'b1, 1'b0, 5'd16, 32'h5000_0000, 8'h43, 20'h22222, 1'b1, 1'b1, 1'b0, 2'd0},
        '{1'b1, 1'b1, 5'd5,  32'h0000_0100, 8'h9C, 20'hABCDE, 1'b1, 1'b1, 1'b0, 2'd0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_en = 1'b0, cfg_long = 1'b0;
    logic [31:0]  cfg_base = '0;
    logic [4:0]   cfg_size = '0;
    logic         miss_valid = 1'b0, miss_side = 1'b0;
    logic [7:0]   miss_rid = '0;
    logic [19:0]  miss_vpn = '0;
    logic [5:0]   miss_ps = '0;
    logic         rd_ready = 1'b0, rd_rvalid = 1'b0, rd_xmiss = 1'b0;
    logic [255:0] rd_data = '0;
    logic         miss_ready, rd_req, rd_long;
    logic [31:0]  rd_addr;
    logic         inst_valid, inst_long, inst_side, nf_pulse, fault_pulse;
    logic [7:0]   inst_rid;
    logic [19:0]  inst_vpn;
    logic [5:0]   inst_ps;
    logic [255:0] inst_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rdreq_cnt = 0;

    always #2 clk = ~clk;

    hashed_walker u_hashed_walker (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_en), .cfg_long(cfg_long), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_rid(miss_rid),
        .miss_vpn(miss_vpn), .miss_ps(miss_ps), .miss_side(miss_side),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_long(rd_long), .rd_ready(rd_ready),
        .rd_rvalid(rd_rvalid), .rd_xmiss(rd_xmiss), .rd_data(rd_data),
        .inst_valid(inst_valid), .inst_long(inst_long), .inst_side(inst_side),
        .inst_rid(inst_rid), .inst_vpn(inst_vpn), .inst_ps(inst_ps),
        .inst_data(inst_data), .nf_pulse(nf_pulse), .fault_pulse(fault_pulse)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_req) rdreq_cnt <= rdreq_cnt + 1;
        if (cyc == 20000) begin
            n_fail = n_fail + 1;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input vec_t v);
        logic [31:0] m;
        m = (32'd1 << v.size) - 32'd1;
        if (v.fmt_long)
            return v.base + (((32'(v.rid) ^ 32'(v.vpn)) << 5) & m);
        else
            return v.base + (((32'(v.vpn) << 3) & m) | (32'(v.rid) << v.size));
    endfunction

    task automatic run_vec(input int idx);
        vec_t         v;
        logic [255:0] d;
        logic [255:0] exp_data;
        logic [27:0]  tag;
        logic         e_inst, e_nf, e_fault;
        string        why;
        int           snap;
        v = VECS[idx];
        tag = {v.rid, v.vpn};
        d = {8{32'hC0DE_0000 | 32'(idx)}};
        d[0] = v.present;
        d[91:64] = v.tag_ok ? tag : (tag ^ 28'h0000100);
        exp_data = v.fmt_long ? d : {192'b0, d[63:0]};
        e_inst = 1'b0; e_nf = 1'b0; e_fault = 1'b0;
        if (!v.en)                        begin e_nf = 1'b1;    why = "R2";  end
        else if (v.xmiss)                 begin e_fault = 1'b1; why = "R7";  end
        else if (!v.present)              begin e_nf = 1'b1;    why = "R8";  end
        else if (v.fmt_long && !v.tag_ok) begin e_nf = 1'b1;    why = "R9";  end
        else                              begin e_inst = 1'b1;  why = (v.tag_ok ? "R10" : "R9"); end

        @(negedge clk);
        chk("R1 idle ready", 256'(miss_ready), 256'(1'b1));
        cfg_en = v.en; cfg_long = v.fmt_long; cfg_base = v.base; cfg_size = v.size;
        miss_rid = v.rid; miss_vpn = v.vpn; miss_ps = 6'(12 + idx); miss_side = idx[0];
        miss_valid = 1'b1;
        snap = rdreq_cnt;
        @(negedge clk);
        miss_valid = 1'b0;
        // R12: scramble inputs once the request has been taken
        cfg_base = ~v.base; cfg_size = v.size ^ 5'd7; cfg_long = ~v.fmt_long;
        miss_rid = ~v.rid; miss_vpn = ~v.vpn;
        if (!v.en) begin
            chk("R2 nf after accept", 256'({inst_valid, nf_pulse, fault_pulse}), 256'(3'b010));
            chk("R2 no read", 256'(rd_req), 256'(1'b0));
            @(negedge clk);
            chk("R11 pulse ends, ready back", 256'({miss_ready, nf_pulse}), 256'(2'b10));
            chk("R2 read count", 256'(rdreq_cnt - snap), 256'(0));
        end else begin
            chk("R6 req rises", 256'(rd_req), 256'(1'b1));
            chk(v.fmt_long ? "R4 addr" : "R3 addr", 256'(rd_addr), 256'(exp_addr(v)));
            chk("R5 size", 256'(rd_long), 256'(v.fmt_long));
            chk("R1 busy", 256'(miss_ready), 256'(1'b0));
            for (int s = 0; s < int'(v.stall); s++) begin
                @(negedge clk);
                chk("R6 held", 256'(rd_req), 256'(1'b1));
                chk("R12 addr frozen", 256'(rd_addr), 256'(exp_addr(v)));
            end
            rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0;
            chk("R6 req drops", 256'(rd_req), 256'(1'b0));
            chk("R1 busy wait", 256'(miss_ready), 256'(1'b0));
            @(negedge clk);
            chk("R11 no early result", 256'({inst_valid, nf_pulse, fault_pulse}), 256'(0));
            rd_rvalid = 1'b1; rd_data = d; rd_xmiss = v.xmiss;
            @(negedge clk);
            rd_rvalid = 1'b0; rd_data = '0; rd_xmiss = 1'b0;
            chk({why, " result"}, 256'({inst_valid, nf_pulse, fault_pulse}),
                256'({e_inst, e_nf, e_fault}));
            if (e_inst) begin
                chk("R10 data", inst_data, exp_data);
                chk("R10 fields", 256'({inst_rid, inst_vpn, inst_ps, inst_side, inst_long}),
                    256'({v.rid, v.vpn, 6'(12 + idx), idx[0], v.fmt_long}));
            end
            @(negedge clk);
            chk("R11 single pulse", 256'({miss_ready, inst_valid, nf_pulse, fault_pulse}),
                256'(4'b1000));
        end
        cfg_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R13 reset ready", 256'({miss_ready, rd_req}), 256'(2'b10));
        chk("R11 reset quiet", 256'({inst_valid, nf_pulse, fault_pulse}), 256'(0));
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) run_vec(i);

        // R13: reset while waiting for a response
        cfg_en = 1'b1; cfg_long = 1'b1; cfg_base = 32'h7000_0000; cfg_size = 5'd12;
        miss_rid = 8'h5A; miss_vpn = 20'h0F00D; miss_valid = 1'b1;
        @(negedge clk);
        miss_valid = 1'b0;
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
        chk("R13 in wait", 256'({miss_ready, rd_req}), 256'(2'b00));
        rst_n = 1'b0;
        @(negedge clk);
        chk("R13 aborted", 256'({miss_ready, rd_req}), 256'(2'b10));
        rst_n = 1'b1;
        rd_rvalid = 1'b1; rd_data = 256'h1;
        @(negedge clk);
        rd_rvalid = 1'b0; rd_data = '0;
        chk("R13 stale response ignored", 256'({inst_valid, nf_pulse, fault_pulse}), 256'(0));

        // a walk after the abort still works
        run_vec(0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule